// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Line Polarity and Break Control

This block is a full-duplex asynchronous serial port with a single-word buffer in each direction. A host reaches it through a small word-wide register port. It writes a byte to queue it for transmission and reads a byte once one has arrived. A control word selects parity, inverts the receive input and the transmit output independently, enables the two interrupt sources, forces a break on the transmit line and clears the error flags. A divisor register sets the bit rate.

The receiver oversamples its input sixteen times per bit. It qualifies a start bit at its centre and then samples each later bit at its centre. Parity errors, framing errors and overruns are sticky until a clear command. Their OR appears as a single summary bit in the status word. A single interrupt line combines "byte waiting" and "transmit buffer free", each gated by its own enable.

Top module: `serial_port_core`

## Requirements
- R1: After reset the status word reads 0x0100 plus bit 13 equal to the receive pin level, tx_out is high and irq is low.
- R2: A byte written to address 0 is sent on tx_out as one low start bit, 8 data bits LSB first, an optional parity bit and one high stop bit. Each bit lasts 16*(D+1) clocks, where D is the divisor written to address 2. When control bit 2 is set, the transmit line level is inverted.
- R3: Control bit 1 enables parity. Control bit 0 selects the parity sense: when it is 1 the count of ones over data and parity is odd, and when it is 0 the count is even.
- R4: A received frame of the same format is placed in the receive buffer, which is read at address 0, and sets status bit 7. When control bit 3 is set, the rx_in level is inverted before decoding.
- R5: A received parity bit that mismatches the selected sense sets status bit 9. A low stop bit sets status bit 10.
- R6: A byte that completes while status bit 7 is still set raises status bit 11 and leaves the buffered byte unchanged.
- R7: Status bit 15 is the OR of bits 9, 10 and 11. These flags stay set until a write to address 1 with bit 6 set clears all three.
- R8: Reading address 0 clears status bit 7.
- R9: Status bit 8 (transmit buffer empty) falls on a data write and rises when the transmitter takes the byte to start its frame.
- R10: While control bit 14 is set, tx_out is held at the space level (low before inversion), no new frame starts, and status bit 14 reads 1.
- R11: irq is high exactly when (bit 7 and control bit 5) or (bit 8 and control bit 4).
- R12: Status bits 4..0 read back control bits 4..0, and status bit 13 reads the raw rx_in pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control (write) / status (read), 2 divisor |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 0 consumes the received byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the cycle-to-cycle handshakes. These are: a data write drops the buffer-empty flag, a data read clears the full flag, the full flag holds until it is read, an arrival into a full buffer raises overrun, a clear command empties the error flags, and break forces the space level onto the pin. Only the bench scenarios can show that frames are encoded and decoded bit for bit with the right parity sense and bit period under each polarity. They also show that a bad parity or stop bit is caught, that the old byte survives an overrun, and that a held-off frame goes out once break is released.

// File: rtl/sp_pkg.sv
// Shared constants and types for the serial port.
// Assumes a 16-bit register word; field positions are fixed by the status layout.
package sp_pkg;
    localparam int REG_W = 16;
    localparam int OVS_W = 4;                   // 16x oversampling

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;

    localparam int C_ODD  = 0;
    localparam int C_PEN  = 1;
    localparam int C_TINV = 2;
    localparam int C_RINV = 3;
    localparam int C_TIE  = 4;
    localparam int C_RIE  = 5;
    localparam int C_CLR  = 6;
    localparam int C_BRK  = 14;

    localparam int S_RBF = 7;
    localparam int S_TBE = 8;
    localparam int S_PE  = 9;
    localparam int S_FE  = 10;
    localparam int S_OE  = 11;
    localparam int S_PIN = 13;
    localparam int S_BRK = 14;
    localparam int S_ERR = 15;

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

    typedef struct packed {
        logic brk;
        logic rie;
        logic tie;
        logic rinv;
        logic tinv;
        logic pen;
        logic odd;
    } ctrl_t;
endpackage

// File: rtl/sp_tx.sv
// Transmit engine: one holding word plus a frame shifter.
// Assumes div is stable during a frame; its prescaler restarts at each frame
// so every bit lasts exactly 16*(div+1) clocks. Break forces the line to
// space before inversion and keeps a waiting byte from starting.
module sp_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              pen,
    input  logic              odd,
    input  logic              brk,
    input  logic              inv,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              tbe,
    output logic              tx_out
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]  idx, last;
    logic [DIV_W-1:0]  pre;
    logic [sp_pkg::OVS_W-1:0] sub;
    logic              busy, start, line;

    assign start = !busy && hold_full && !brk;
    assign tbe   = !hold_full;

    // Holding register: filled by a host write, emptied when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (load) begin
            hold_full <= 1'b1;
            hold_data <= load_data;
        end else if (start) begin
            hold_full <= 1'b0;
        end
    end

    // Frame shifter with its own bit-rate prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= '1;
            idx   <= '0;
            last  <= '0;
            pre   <= '0;
            sub   <= '0;
        end else if (start) begin
            frame <= pen ? {1'b1, (^hold_data) ^ odd, hold_data, 1'b0}
                         : {2'b11, hold_data, 1'b0};
            last  <= pen ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
            idx   <= '0;
            pre   <= '0;
            sub   <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            if (pre == div) begin
                pre <= '0;
                sub <= sub + 1'b1;
                if (sub == '1) begin
                    if (idx == last) begin
                        busy <= 1'b0;
                    end else begin
                        frame <= frame >> 1;
                        idx   <= idx + 1'b1;
                    end
                end
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assign line = brk ? 1'b0 : (busy ? frame[0] : 1'b1);

    // Registered pin driver with output polarity applied.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_out <= 1'b1;
        else        tx_out <= line ^ inv;
    end
endmodule

// File: rtl/sp_rx.sv
// Receive engine: synchroniser, 16x oversampled frame decoder, one-word
// buffer and sticky error flags. Assumes the line has already had its
// polarity corrected; a start bit must still be low at its centre.
module sp_rx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              pen,
    input  logic              odd,
    input  logic              line_in,
    input  logic              rd_take,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_buf,
    output logic              rbf,
    output logic              pe,
    output logic              fe,
    output logic              oe,
    output logic              done
);
    import sp_pkg::*;
    localparam int BIT_W = $clog2(DATA_W);

    logic s1, s2, tick, mid, pbit, pe_set, fe_set;
    logic [DIV_W-1:0]  pre;
    logic [OVS_W-1:0]  sub;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] sh;
    rx_state_t st;

    // Two-flop synchroniser on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
        end
    end

    assign tick   = (pre == div);
    assign mid    = tick && (sub == '1);
    assign done   = (st == RX_STOP) && mid;
    assign fe_set = done && !s2;
    assign pe_set = done && pen && (pbit != ((^sh) ^ odd));

    // Frame sequencer: centre the start bit, then sample every 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            pre  <= '0;
            sub  <= '0;
            bitn <= '0;
            sh   <= '0;
            pbit <= 1'b0;
        end else if (st == RX_IDLE) begin
            pre <= '0;
            sub <= '0;
            if (!s2) st <= RX_START;
        end else begin
            if (tick) begin
                pre <= '0;
                sub <= sub + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
            case (st)
                RX_START: if (tick && sub == OVS_W'(7)) begin
                    sub  <= '0;
                    bitn <= '0;
                    st   <= s2 ? RX_IDLE : RX_DATA;
                end
                RX_DATA: if (mid) begin
                    sh   <= {s2, sh[DATA_W-1:1]};
                    bitn <= bitn + 1'b1;
                    if (bitn == BIT_W'(DATA_W - 1)) st <= pen ? RX_PAR : RX_STOP;
                end
                RX_PAR: if (mid) begin
                    pbit <= s2;
                    st   <= RX_STOP;
                end
                RX_STOP: if (mid) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end

    // Buffer and sticky flags; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
            rbf    <= 1'b0;
            pe     <= 1'b0;
            fe     <= 1'b0;
            oe     <= 1'b0;
        end else begin
            if (done && !rbf) begin
                rx_buf <= sh;
                rbf    <= 1'b1;
            end else if (rd_take) begin
                rbf <= 1'b0;
            end
            pe <= (pe && !err_clr) || pe_set;
            fe <= (fe && !err_clr) || fe_set;
            oe <= (oe && !err_clr) || (done && rbf);
        end
    end
endmodule

// File: rtl/serial_port_core.sv
// Serial port top: register decode, control and divisor storage, status
// assembly and interrupt combine around the transmit and receive engines.
// Assumes reads are combinational and a data read strobe consumes the byte.
module serial_port_core #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rx_in,
    output logic        tx_out,
    output logic        irq
);
    import sp_pkg::*;

    ctrl_t             ctrl;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_full, tx_empty, err_par, err_frm, err_ovr, rx_done;
    logic              wr_data, wr_ctrl, wr_div, rd_take, err_clr;
    logic [REG_W-1:0]  status, div_ext, data_ext;

    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_div  = bus_wr && (bus_addr == A_DIV);
    assign rd_take = bus_rd && (bus_addr == A_DATA);
    assign err_clr = wr_ctrl && bus_wdata[C_CLR];

    // Control and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            div_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.odd  <= bus_wdata[C_ODD];
                ctrl.pen  <= bus_wdata[C_PEN];
                ctrl.tinv <= bus_wdata[C_TINV];
                ctrl.rinv <= bus_wdata[C_RINV];
                ctrl.tie  <= bus_wdata[C_TIE];
                ctrl.rie  <= bus_wdata[C_RIE];
                ctrl.brk  <= bus_wdata[C_BRK];
            end
            if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    sp_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .div(div_q), .pen(ctrl.pen), .odd(ctrl.odd),
        .brk(ctrl.brk), .inv(ctrl.tinv), .load(wr_data),
        .load_data(bus_wdata[DATA_W-1:0]), .tbe(tx_empty), .tx_out(tx_out)
    );

    sp_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .div(div_q), .pen(ctrl.pen), .odd(ctrl.odd),
        .line_in(rx_in ^ ctrl.rinv), .rd_take(rd_take), .err_clr(err_clr),
        .rx_buf(rx_buf), .rbf(rx_full), .pe(err_par), .fe(err_frm),
        .oe(err_ovr), .done(rx_done)
    );

    // Status word assembly and zero-extended register views.
    always_comb begin
        status        = '0;
        status[C_ODD]  = ctrl.odd;
        status[C_PEN]  = ctrl.pen;
        status[C_TINV] = ctrl.tinv;
        status[C_RINV] = ctrl.rinv;
        status[C_TIE]  = ctrl.tie;
        status[S_RBF]  = rx_full;
        status[S_TBE]  = tx_empty;
        status[S_PE]   = err_par;
        status[S_FE]   = err_frm;
        status[S_OE]   = err_ovr;
        status[S_PIN]  = rx_in;
        status[S_BRK]  = ctrl.brk;
        status[S_ERR]  = err_par | err_frm | err_ovr;
        div_ext        = '0;
        div_ext[DIV_W-1:0] = div_q;
        data_ext       = '0;
        data_ext[DATA_W-1:0] = rx_buf;
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = data_ext;
            A_CTRL:  bus_rdata = status;
            A_DIV:   bus_rdata = div_ext;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = (rx_full && ctrl.rie) || (tx_empty && ctrl.tie);
endmodule

// File: rtl/sp_checker.sv
// Cycle-level protocol checks for serial_port_core, bound into every instance.
module sp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       clr_bit,
    input logic       tx_out,
    input logic       brk,
    input logic       tinv,
    input logic       rbf,
    input logic       tbe,
    input logic       pe,
    input logic       fe,
    input logic       oe,
    input logic       rx_done
);
    // R9
    tbe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> !tbe);

    // R10
    break_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (tx_out == $past(tinv)));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && !rx_done) |=> !rbf);

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbf && !(bus_rd && bus_addr == 2'd0)) |=> rbf);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rbf) |=> oe);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && clr_bit && !rx_done) |=> !(pe || fe || oe));
endmodule

bind serial_port_core sp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .clr_bit(bus_wdata[6]), .tx_out(tx_out),
    .brk(ctrl.brk), .tinv(ctrl.tinv), .rbf(rx_full), .tbe(tx_empty),
    .pe(err_par), .fe(err_frm), .oe(err_ovr), .rx_done(rx_done)
);

// File: tb/sim_serial_port_core.sv
module sim_serial_port_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rx_pin = 1'b1;
    logic        tx_out;
    logic        irq;
    int checks = 0;
    int errors = 0;

    serial_port_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .rx_in(rx_pin),
        .tx_out(tx_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic take_byte(output logic [15:0] v);
        @(negedge clk);
        addr = 2'd0; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen, input logic odd,
                              input logic inv, input logic bad_par, input logic bad_stop,
                              input int bt);
        logic [10:0] f;
        int n;
        if (pen) begin
            f = {~bad_stop, (^d) ^ odd ^ bad_par, d, 1'b0};
            n = 11;
        end else begin
            f = {1'b1, ~bad_stop, d, 1'b0};
            n = 10;
        end
        for (int k = 0; k < n; k++) begin
            rx_pin = f[k] ^ inv;
            repeat (bt) @(negedge clk);
        end
        rx_pin = 1'b1 ^ inv;
    endtask

    task automatic decode(input logic inv, input logic pen, input int bt,
                          output logic [7:0] d, output logic p,
                          output logic stop, output logic found);
        found = 1'b0; d = '0; p = 1'b0; stop = 1'b0;
        for (int k = 0; k < 8 * bt; k++) begin
            if (tx_out === ~inv) break;
            @(negedge clk);
        end
        for (int k = 0; k < 40 * bt; k++) begin
            if (tx_out === inv) begin
                found = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (found) begin
            repeat (bt / 2) @(negedge clk);
            for (int b = 0; b < 8; b++) begin
                repeat (bt) @(negedge clk);
                d[b] = tx_out ^ inv;
            end
            if (pen) begin
                repeat (bt) @(negedge clk);
                p = tx_out ^ inv;
            end
            repeat (bt) @(negedge clk);
            stop = tx_out ^ inv;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  d;
        logic        p, stop, found;
        int          bt, cnt;

        // R1, R12: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(2'd1, v);
        chk("R1", "status after reset", v, 16'h2100);
        chk("R1", "tx_out idle", {15'd0, tx_out}, 16'd1);
        chk("R1", "irq idle", {15'd0, irq}, 16'd0);
        rx_pin = 1'b0;
        peek(2'd1, v);
        chk("R12", "raw pin bit low", v, 16'h0100);
        rx_pin = 1'b1;

        // R2, R3, R9: transmit sweep over all bytes and configurations
        bt = 16;
        for (int i = 0; i < 256; i++) begin
            logic o, pe_, ti;
            o = i[0]; pe_ = i[1]; ti = i[2];
            wr_reg(2'd1, {13'd0, ti, pe_, o});
            repeat (3) @(negedge clk);
            wr_reg(2'd0, 16'(i));
            peek(2'd1, v);
            chk("R9", "tbe low after write", {15'd0, v[8]}, 16'd0);
            decode(ti, pe_, bt, d, p, stop, found);
            chk("R2", "frame start seen", {15'd0, found}, 16'd1);
            chk("R2", "tx data", {8'd0, d}, 16'(i));
            if (pe_) chk("R3", "tx parity", {15'd0, p}, {15'd0, (^i[7:0]) ^ o});
            chk("R2", "tx stop", {15'd0, stop}, 16'd1);
            peek(2'd1, v);
            chk("R9", "tbe high after start", {15'd0, v[8]}, 16'd1);
            repeat (bt) @(negedge clk);
        end

        // R2: exact bit period with divisor 2
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd2, 16'd2);
        peek(2'd2, v);
        chk("R2", "divisor readback", v, 16'd2);
        bt = 48;
        wr_reg(2'd0, 16'h0001);
        for (int k = 0; k < 200 && tx_out !== 1'b0; k++) @(negedge clk);
        cnt = 0;
        while (tx_out === 1'b0 && cnt < 500) begin
            cnt++;
            @(negedge clk);
        end
        chk("R2", "start bit length", 16'(cnt), 16'd48);
        repeat (11 * bt) @(negedge clk);
        wr_reg(2'd2, 16'd0);
        bt = 16;

        // R4, R8, R12, R3: receive sweep over all bytes and configurations
        for (int i = 0; i < 256; i++) begin
            logic o, pe_, ri;
            logic [15:0] cfg;
            o = i[0]; pe_ = i[1]; ri = i[2];
            cfg = {12'd0, ri, 1'b0, pe_, o};
            wr_reg(2'd1, cfg);
            rx_pin = 1'b1 ^ ri;
            repeat (2 * bt) @(negedge clk);
            peek(2'd1, v);
            chk("R12", "status echo and pin", v, 16'h0100 | cfg | {2'b0, rx_pin, 13'd0});
            send_frame(8'(i), pe_, o, ri, 1'b0, 1'b0, bt);
            repeat (4) @(negedge clk);
            peek(2'd1, v);
            chk("R4", "status after frame", v, 16'h0180 | cfg | {2'b0, rx_pin, 13'd0});
            take_byte(v);
            chk("R4", "rx data", v, 16'(i));
            peek(2'd1, v);
            chk("R8", "rbf cleared by read", {15'd0, v[7]}, 16'd0);
        end

        // R5, R7: parity error, summary bit and clear
        wr_reg(2'd1, 16'h0002);
        rx_pin = 1'b1;
        repeat (2 * bt) @(negedge clk);
        send_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, bt);
        repeat (4) @(negedge clk);
        peek(2'd1, v);
        chk("R5", "parity error flag", {15'd0, v[9]}, 16'd1);
        chk("R7", "summary on parity", {15'd0, v[15]}, 16'd1);
        take_byte(v);
        wr_reg(2'd1, 16'h0042);
        peek(2'd1, v);
        chk("R7", "clear error", v & 16'h8E00, 16'h0000);

        // R5, R7: framing error stays sticky across a good frame
        send_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, bt);
        repeat (2 * bt) @(negedge clk);
        peek(2'd1, v);
        chk("R5", "framing error flag", v & 16'h8E00, 16'h8400);
        take_byte(v);
        send_frame(8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, bt);
        repeat (4) @(negedge clk);
        peek(2'd1, v);
        chk("R7", "framing error sticky", v & 16'h8E00, 16'h8400);
        take_byte(v);
        chk("R5", "good byte after error", v, 16'h0011);
        wr_reg(2'd1, 16'h0040);

        // R6: overrun keeps the old byte
        send_frame(8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, bt);
        repeat (4) @(negedge clk);
        send_frame(8'hB2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, bt);
        repeat (4) @(negedge clk);
        peek(2'd1, v);
        chk("R6", "overrun flag and summary", v & 16'h8E80, 16'h8880);
        take_byte(v);
        chk("R6", "old byte kept", v, 16'h00A1);
        wr_reg(2'd1, 16'h0040);

        // R11: interrupt combinations
        wr_reg(2'd1, 16'h0020);
        peek(2'd1, v);
        chk("R11", "irq low, rx enabled, buffer empty", {15'd0, irq}, 16'd0);
        send_frame(8'h3E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, bt);
        repeat (4) @(negedge clk);
        chk("R11", "irq on receive", {15'd0, irq}, 16'd1);
        take_byte(v);
        chk("R11", "irq drops after read", {15'd0, irq}, 16'd0);
        wr_reg(2'd1, 16'h0010);
        chk("R11", "irq on tx empty", {15'd0, irq}, 16'd1);
        wr_reg(2'd1, 16'h0000);
        send_frame(8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, bt);
        repeat (4) @(negedge clk);
        chk("R11", "irq masked with rbf set", {15'd0, irq}, 16'd0);
        take_byte(v);

        // R10: break holds the line and defers the frame
        wr_reg(2'd1, 16'h4000);
        repeat (3) @(negedge clk);
        chk("R10", "break level", {15'd0, tx_out}, 16'd0);
        peek(2'd1, v);
        chk("R10", "break status bit", {15'd0, v[14]}, 16'd1);
        wr_reg(2'd0, 16'h003C);
        repeat (3 * bt) @(negedge clk);
        chk("R10", "line held during break", {15'd0, tx_out}, 16'd0);
        peek(2'd1, v);
        chk("R10", "frame held off", {15'd0, v[8]}, 16'd0);
        wr_reg(2'd1, 16'h0000);
        decode(1'b0, 1'b0, bt, d, p, stop, found);
        chk("R10", "deferred byte sent", {8'd0, d}, 16'h003C);
        chk("R10", "deferred stop", {15'd0, stop}, 16'd1);
        repeat (bt) @(negedge clk);
        wr_reg(2'd1, 16'h4004);
        repeat (3) @(negedge clk);
        chk("R10", "break level inverted", {15'd0, tx_out}, 16'd1);
        wr_reg(2'd1, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule